// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block sits between a processor-side operand request and an external 16-bit data bus. It accepts a byte, word or long-word read or write. It then runs as many bus cycles as the responding port needs to move that operand. The port's width is not configured anywhere. The block learns it on every bus cycle from a two-bit active-low acknowledge pair.

Each bus cycle starts on the assumption of a 16-bit port, so the block always offers as many bytes as the address alignment allows. The block drives the cycle's address and its remaining-size code. It steers write bytes onto the proper lanes and gathers read bytes into a right-justified operand. A one-clock completion pulse follows the last cycle. A reserved acknowledge code aborts the transfer and raises a one-clock error pulse instead.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset the block is idle: `bus_cyc`, `done` and `err` are 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. The size code is 2'b00 for a byte, 2'b01 for a word, and 2'b10 or 2'b11 for a long word. On every bus cycle, `bus_addr` shows the address of the next operand byte. `bus_size` shows the number of bytes still to move, with 2'b00 meaning four.
- R3: With `ack_n` = 2'b11 the current cycle is held in wait states, and address, size, direction and write data stay unchanged.
- R4: `ack_n` = 2'b10 (bit 1 high, bit 0 low) ends the cycle as an 8-bit port. Exactly one byte moves, on lines [15:8]. The address then rises by 1 and the remaining count falls by 1.
- R5: `ack_n` = 2'b01 ends the cycle as a 16-bit port. Two bytes move when the address is even and at least two remain. Otherwise one byte moves: on lines [15:8] at an even address, or on [7:0] at an odd one. The address and remaining count advance by the bytes moved.
- R6: Write data is driven on `bus_dout`. At an even address with at least two bytes left, the upper lane carries the next operand byte and the lower lane the one after it. Otherwise the next byte is driven on both lanes.
- R7: Operand bytes move most significant first. A long word at an even address takes two cycles on a 16-bit port and four on an 8-bit port.
- R8: Read data on `rdata` is right-justified, with the first byte transferred as the most significant byte and zeros above the operand.
- R9: `done` is 1 for exactly one clock, in the clock after the final acknowledge. At that point `bus_cyc` is 0, `req_ready` is 1 and `rdata` holds the assembled operand.
- R10: `ack_n` = 2'b00 aborts the transfer. `err` is 1 for one clock, `done` stays 0 and `bus_cyc` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operand request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Operand start address |
| req_wdata | input | 32 | Write operand, right-justified |
| req_ready | output | 1 | Block idle and able to take a request |
| bus_cyc | output | 1 | A bus cycle is open |
| bus_write | output | 1 | Direction of the open cycle |
| bus_addr | output | ADDR_W | Address of the open cycle |
| bus_size | output | 2 | Bytes remaining, 0 = four |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| ack_n | input | 2 | Active-low acknowledge pair |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock protocol error pulse |
| rdata | output | 32 | Assembled read operand |

## Verification
On every clock, the assertions cover several local rules. Wait states freeze the cycle. An 8-bit acknowledge advances the address and count by one. Single-byte and odd-address writes are mirrored on both lanes. The done and error pulses last one clock and never coincide. The reserved code always ends in an error. Only the bench's scenarios can show the end-to-end results. These are the exact cycle sequence for each size, alignment and port width, the byte order, and the assembled read value, all checked against a behavioural byte-by-byte model.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    localparam int OP_BYTES = 4;
    localparam int OP_W     = 8 * OP_BYTES;
    localparam int LANE_W   = 16;

    typedef enum logic {ST_IDLE, ST_BUS} dbs_state_e;

    // acknowledge pair codes (active low)
    localparam logic [1:0] ACK_WAIT  = 2'b11;
    localparam logic [1:0] ACK_PORT8 = 2'b10;
    localparam logic [1:0] ACK_PORT16 = 2'b01;
    localparam logic [1:0] ACK_RSVD  = 2'b00;
endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
    import dbs_pkg::*;
(
    input  logic [1:0] ack_n,
    input  logic       pair_ok,
    output logic       cyc_end,
    output logic       cyc_err,
    output logic [1:0] moved,
    output logic       take_low
);
    always_comb begin
        cyc_end  = 1'b0;
        cyc_err  = 1'b0;
        moved    = 2'd0;
        take_low = 1'b0;
        case (ack_n)
            ACK_PORT8: begin
                cyc_end = 1'b1;
                moved   = 2'd1;
            end
            ACK_PORT16: begin
                cyc_end  = 1'b1;
                moved    = pair_ok ? 2'd2 : 2'd1;
                take_low = 1'b1;
            end
            ACK_RSVD: cyc_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dbs_wr_lanes.sv
module dbs_wr_lanes
    import dbs_pkg::*;
(
    input  logic [OP_W-1:0]   wbuf,
    input  logic              pair_ok,
    output logic [LANE_W-1:0] dout
);
    always_comb begin
        if (pair_ok) dout = wbuf[OP_W-1 -: 16];
        else         dout = {wbuf[OP_W-1 -: 8], wbuf[OP_W-1 -: 8]};
    end
endmodule

// File: rtl/dbs_rd_merge.sv
module dbs_rd_merge
    import dbs_pkg::*;
(
    input  logic [OP_W-1:0]   rbuf,
    input  logic [LANE_W-1:0] din,
    input  logic [1:0]        moved,
    input  logic              odd_lane,
    output logic [OP_W-1:0]   rbuf_next
);
    logic [7:0] one_byte;
    always_comb begin
        one_byte = odd_lane ? din[7:0] : din[15:8];
        case (moved)
            2'd2:    rbuf_next = {rbuf[OP_W-17:0], din};
            2'd1:    rbuf_next = {rbuf[OP_W-9:0], one_byte};
            default: rbuf_next = rbuf;
        endcase
    end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
    import dbs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              bus_cyc,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [LANE_W-1:0] bus_dout,
    input  logic [LANE_W-1:0] bus_din,
    input  logic [1:0]        ack_n,
    output logic              done,
    output logic              err,
    output logic [OP_W-1:0]   rdata
);
    typedef struct packed {
        dbs_state_e        st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        rem;
        logic [OP_W-1:0]   wbuf;
        logic [OP_W-1:0]   rbuf;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    logic        pair_ok;
    logic        cyc_end, cyc_err, take_low;
    logic [1:0]  moved;
    logic [OP_W-1:0] rbuf_next;

    assign pair_ok = (r_q.rem >= 3'd2) && !r_q.addr[0];

    dbs_ack_decode u_dec (
        .ack_n    (ack_n),
        .pair_ok  (pair_ok),
        .cyc_end  (cyc_end),
        .cyc_err  (cyc_err),
        .moved    (moved),
        .take_low (take_low)
    );

    dbs_wr_lanes u_lanes (
        .wbuf    (r_q.wbuf),
        .pair_ok (pair_ok),
        .dout    (bus_dout)
    );

    dbs_rd_merge u_merge (
        .rbuf      (r_q.rbuf),
        .din       (bus_din),
        .moved     (moved),
        .odd_lane  (take_low && r_q.addr[0]),
        .rbuf_next (rbuf_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_BUS;
                    r_d.wr   = req_write;
                    r_d.addr = req_addr;
                    r_d.rbuf = '0;
                    case (req_size)
                        2'b00: begin
                            r_d.rem  = 3'd1;
                            r_d.wbuf = {req_wdata[7:0], 24'h0};
                        end
                        2'b01: begin
                            r_d.rem  = 3'd2;
                            r_d.wbuf = {req_wdata[15:0], 16'h0};
                        end
                        default: begin
                            r_d.rem  = 3'd4;
                            r_d.wbuf = req_wdata;
                        end
                    endcase
                end
            end
            ST_BUS: begin
                if (cyc_err) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end else if (cyc_end) begin
                    r_d.addr = r_q.addr + ADDR_W'(moved);
                    r_d.rem  = r_q.rem - {1'b0, moved};
                    r_d.wbuf = (moved == 2'd2) ? {r_q.wbuf[OP_W-17:0], 16'h0}
                                               : {r_q.wbuf[OP_W-9:0], 8'h0};
                    if (!r_q.wr) r_d.rbuf = rbuf_next;
                    if (r_q.rem == {1'b0, moved}) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, wr: 1'b0, addr: '0, rem: 3'd0,
                     wbuf: '0, rbuf: '0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign bus_cyc   = (r_q.st == ST_BUS);
    assign bus_write = bus_cyc && r_q.wr;
    assign bus_addr  = r_q.addr;
    assign bus_size  = r_q.rem[1:0];
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign rdata     = r_q.rbuf;
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              bus_cyc,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [15:0]       bus_dout,
    input logic [1:0]        ack_n,
    input logic              done,
    input logic              err
);
    // R3: wait states freeze the open cycle
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && ack_n == 2'b11 |=> bus_cyc && $stable(bus_addr)
            && $stable(bus_size) && $stable(bus_dout) && $stable(bus_write));

    // R4: 8-bit acknowledge on a non-final cycle moves one byte
    assert_byte_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && ack_n == 2'b10 && bus_size != 2'd1 |=>
            bus_cyc && bus_addr == $past(bus_addr) + 1'b1
            && bus_size == $past(bus_size) - 2'd1);

    // R6: single-byte or odd-address writes are mirrored on both lanes
    assert_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write && (bus_size == 2'd1 || bus_addr[0]) |->
            bus_dout[15:8] == bus_dout[7:0]);

    // R9: done lasts one clock and the block is then idle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_cyc && req_ready ##1 !done);

    // R10: reserved code aborts with a one-clock error and no done
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && ack_n == 2'b00 |=> err && !done && !bus_cyc);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R1: idle state flags are consistent
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != bus_cyc);
endmodule

bind dyn_bus_sizer dbs_checker #(.ADDR_W(ADDR_W)) u_dbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .bus_cyc   (bus_cyc),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_dout  (bus_dout),
    .ack_n     (ack_n),
    .done      (done),
    .err       (err)
);

// File: tb/tb_dyn_bus_sizer.sv
`timescale 1ns/1ps
module tb_dyn_bus_sizer;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_ready;
    logic          bus_cyc, bus_write;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic [1:0]    ack_n = 2'b11;
    logic          done, err;
    logic [31:0]   rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dyn_bus_sizer #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .bus_cyc(bus_cyc), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_dout(bus_dout),
        .bus_din(bus_din), .ack_n(ack_n), .done(done), .err(err), .rdata(rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_b(input logic [AW-1:0] a);
        return a[7:0] * 8'd29 + 8'h41;
    endfunction

    // behavioural model: walk the operand byte by byte
    task automatic run_xfer(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                            input logic [31:0] wd, input bit p8, input int waits,
                            input int exp_cycles);
        int n;
        int rem;
        int idx;
        int ncyc;
        int mv;
        bit dual;
        logic [AW-1:0] cur;
        logic [7:0] op [4];
        logic [15:0] exp_dout;
        logic [31:0] exp_r;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        for (int i = 0; i < n; i++) op[i] = 8'(wd >> (8 * (n - 1 - i)));
        cur = a; rem = n; idx = 0; ncyc = 0; exp_r = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        while (rem > 0) begin
            dual = (rem >= 2) && !cur[0];
            exp_dout = dual ? {op[idx], op[idx+1]} : {op[idx], op[idx]};
            mv = p8 ? 1 : (dual ? 2 : 1);
            for (int w = 0; w <= waits; w++) begin
                @(negedge clk);
                req_valid = 1'b0;
                chk(bus_cyc == 1'b1, "R2 cycle open", bus_cyc, 1);
                chk(bus_addr == cur, p8 ? "R4 address" : "R5 address", bus_addr, cur);
                chk(bus_size == 2'(rem), "R2 size code", bus_size, 2'(rem));
                chk(bus_write == wr, "R2 direction", bus_write, wr);
                if (wr) chk(bus_dout == exp_dout, w > 0 ? "R3 held data" : "R6 lanes",
                            bus_dout, exp_dout);
                bus_din = p8 ? {mem_b(cur), 8'h00}
                             : {mem_b({cur[AW-1:1], 1'b0}), mem_b({cur[AW-1:1], 1'b1})};
                ack_n = (w < waits) ? 2'b11 : (p8 ? 2'b10 : 2'b01);
            end
            for (int j = 0; j < mv; j++) exp_r = (exp_r << 8) | 32'(mem_b(cur + AW'(j)));
            cur = cur + AW'(mv); rem = rem - mv; idx = idx + mv; ncyc++;
        end
        @(negedge clk);
        ack_n = 2'b11;
        chk(ncyc == exp_cycles, "R7 cycle count", ncyc, exp_cycles);
        chk(done == 1'b1 && err == 1'b0, "R9 done pulse", {done, err}, 2'b10);
        chk(bus_cyc == 1'b0 && req_ready == 1'b1, "R9 idle after done",
            {bus_cyc, req_ready}, 2'b01);
        if (!wr) chk(rdata == exp_r, "R8 read operand", rdata, exp_r);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one clock", done, 0);
        if (!wr) chk(rdata == exp_r, "R9 rdata held", rdata, exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_cyc == 0 && done == 0 && err == 0 && req_ready == 1, "R1 reset idle",
            {bus_cyc, done, err, req_ready}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1 && bus_cyc == 0, "R1 idle after release", {req_ready, bus_cyc}, 2'b10);

        run_xfer(0, 2'b10, 24'h000100, 32'h0, 0, 0, 2);        // R7 long read, 16-bit
        run_xfer(0, 2'b10, 24'h000200, 32'h0, 1, 1, 4);        // R4 long read, 8-bit, waits
        run_xfer(1, 2'b10, 24'h000310, 32'hA1B2C3D4, 0, 0, 2); // R6 long write, 16-bit
        run_xfer(1, 2'b11, 24'h000420, 32'h11223344, 1, 2, 4); // R3 long write, 8-bit
        run_xfer(0, 2'b01, 24'h000501, 32'h0, 0, 0, 2);        // R5 odd word read
        run_xfer(1, 2'b00, 24'h000603, 32'h000000E7, 0, 1, 1); // R6 odd byte write
        run_xfer(0, 2'b00, 24'h000702, 32'h0, 0, 0, 1);        // R5 even byte read, 16-bit
        run_xfer(0, 2'b10, 24'h000811, 32'h0, 0, 0, 3);        // R5 odd long read
        run_xfer(1, 2'b01, 24'h000900, 32'h00005A6B, 1, 0, 2); // R4 word write, 8-bit
        run_xfer(1, 2'b10, 24'h000A05, 32'hCAFEF00D, 0, 0, 3); // R6 odd long write

        // R10: reserved acknowledge aborts
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'b10; req_addr = 24'h000B00;
        @(negedge clk);
        req_valid = 1'b0;
        ack_n = 2'b00;
        @(negedge clk);
        ack_n = 2'b11;
        chk(err == 1 && done == 0 && bus_cyc == 0, "R10 abort", {err, done, bus_cyc}, 3'b100);
        @(negedge clk);
        chk(err == 0 && req_ready == 1, "R10 error one clock", {err, req_ready}, 2'b01);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule